// File: doc/BRIEF.md
# Word Shift and Bit-Count Unit

This block is a 32-bit integer execution slice for the shift-and-count group of a processor's fixed-point pipeline. One operation is issued per cycle. Each operation carries an extended opcode, a source word, a second word that supplies the shift amount (or the compare partner), and a small immediate. The available operations are logical shifts in both directions, arithmetic right shifts by a register amount or by the immediate, a leading-zero count, a per-byte equality compare that returns a byte mask, and sign extension from a byte or a halfword.

All arithmetic is combinational. The result is captured in one register stage when the issue strobe is high, and the output strobe follows one cycle later. The carry flag is held inside the block. Only the two arithmetic right shifts write it, and they report the write on a write-enable pin that is aligned with the result. Every other operation leaves the flag unchanged.

Top module: `wsbc_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `out_valid`, `out_ca_we` and `out_ca` are 0 and `out_result` is all zeros.
- R2: An operation presented with `in_valid` high at a rising edge appears on `out_result` with `out_valid` high right after that edge. With `in_valid` low, `out_valid` goes low, `out_ca_we` goes low, and `out_result` and `out_ca` keep their values.
- R3: Opcode 24 shifts `in_rs` left by `in_rb[4:0]` and fills with zeros. If `in_rb[5]` is 1 the result is zero. Bits of `in_rb` above bit 5 are ignored.
- R4: Opcode 536 shifts `in_rs` right logically, with the same amount rules as R3.
- R5: Opcode 792 shifts `in_rs` right arithmetically by `in_rb[4:0]`. If `in_rb[5]` is 1 the result is 32 copies of the sign bit of `in_rs`. Bits of `in_rb` above bit 5 are ignored.
- R6: Opcode 824 shifts `in_rs` right arithmetically by `in_imm` (0 to 31) and ignores `in_rb`.
- R7: Both arithmetic shifts drive `out_ca_we` high. The new carry is 1 exactly when `in_rs` is negative and at least one 1 bit is shifted out. This means an amount of 0 returns `in_rs` unchanged with carry 0, and a saturating amount with a negative source gives carry 1.
- R8: All other opcodes drive `out_ca_we` low and leave `out_ca` unchanged.
- R9: Opcode 26 returns the number of leading zero bits of `in_rs`, which is 32 for a zero word.
- R10: Opcode 508 compares `in_rs` and `in_rb` byte by byte. Each result byte is 0xFF where the two bytes are equal and 0x00 where they differ.
- R11: Opcode 954 sign-extends `in_rs[7:0]` and opcode 922 sign-extends `in_rs[15:0]` to 32 bits.
- R12: Any other opcode returns zero with `out_valid` still raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue strobe |
| in_op | input | 10 | Extended opcode |
| in_rs | input | 32 | Source word |
| in_rb | input | 32 | Shift amount or compare partner |
| in_imm | input | 5 | Immediate shift amount |
| out_valid | output | 1 | Result strobe, one cycle after issue |
| out_result | output | 32 | Registered result |
| out_ca | output | 1 | Carry flag state |
| out_ca_we | output | 1 | Carry was written by this result |

## Verification
The bench sweeps every 6-bit amount over sign-boundary patterns such as 0x80000000, 0x80000001 and 0x7FFFFFFF, with junk placed in the upper bits of the amount word. A design that decodes more than six amount bits, or that wraps bit 5 into a modulo shift, therefore returns shifted data where the result should saturate. The carry is checked at amount zero, at amounts where only zero bits are lost, and at the saturating amount with a negative source. A wrong lost-bit mask shows up as a spurious carry or a missing one. The leading-zero count is driven with every single-bit word and with zero, all byte-equality masks are applied to the compare, and a set carry is pushed through non-arithmetic opcodes. A design that clobbered the carry on those opcodes would lose it.

// File: rtl/wsbc_pkg.sv
package wsbc_pkg;

  localparam int OPW = 10;

  localparam logic [OPW-1:0] OP_SLW   = 10'd24;
  localparam logic [OPW-1:0] OP_SRW   = 10'd536;
  localparam logic [OPW-1:0] OP_SRAW  = 10'd792;
  localparam logic [OPW-1:0] OP_SRAWI = 10'd824;
  localparam logic [OPW-1:0] OP_CLZ   = 10'd26;
  localparam logic [OPW-1:0] OP_CMPB  = 10'd508;
  localparam logic [OPW-1:0] OP_EXTB  = 10'd954;
  localparam logic [OPW-1:0] OP_EXTH  = 10'd922;

  typedef struct packed {
    logic is_shift;
    logic go_right;
    logic arith;
    logic use_imm;
    logic is_clz;
    logic is_cmpb;
    logic is_ext;
    logic ext_half;
  } dec_t;

  function automatic dec_t wsbc_decode(input logic [OPW-1:0] op);
    dec_t d;
    d = '0;
    case (op)
      OP_SLW:   d.is_shift = 1'b1;
      OP_SRW:   begin d.is_shift = 1'b1; d.go_right = 1'b1; end
      OP_SRAW:  begin d.is_shift = 1'b1; d.go_right = 1'b1; d.arith = 1'b1; end
      OP_SRAWI: begin d.is_shift = 1'b1; d.go_right = 1'b1; d.arith = 1'b1;
                      d.use_imm = 1'b1; end
      OP_CLZ:   d.is_clz = 1'b1;
      OP_CMPB:  d.is_cmpb = 1'b1;
      OP_EXTB:  d.is_ext = 1'b1;
      OP_EXTH:  begin d.is_ext = 1'b1; d.ext_half = 1'b1; end
      default:  d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/wsbc_shifter.sv
module wsbc_shifter #(
  parameter int WIDTH = 32,
  parameter int AMTW  = $clog2(WIDTH) + 1
) (
  input  logic [WIDTH-1:0] src,
  input  logic [AMTW-1:0]  amt,
  input  logic             go_right,
  input  logic             arith,
  output logic [WIDTH-1:0] res,
  output logic             ca
);
  localparam int SHW = AMTW - 1;

  logic             big;
  logic [SHW-1:0]   sh;
  logic             neg;
  logic [WIDTH-1:0] lost_mask;
  logic             lost_one;

  assign big = amt[AMTW-1];
  assign sh  = amt[SHW-1:0];
  assign neg = src[WIDTH-1];

  // Low sh bits set: the bits that leave the word on a right shift.
  // Evaluated beside the shifter, not after it.
  assign lost_mask = ~({WIDTH{1'b1}} << sh);
  assign lost_one  = |(src & lost_mask);

  always_comb begin
    res = '0;
    ca  = 1'b0;
    if (!go_right) begin
      res = big ? '0 : (src << sh);
    end else if (!arith) begin
      res = big ? '0 : (src >> sh);
    end else if (big) begin
      res = {WIDTH{neg}};
      ca  = neg;
    end else begin
      res = $unsigned($signed(src) >>> sh);
      ca  = neg & lost_one;
    end
  end
endmodule

// File: rtl/wsbc_clz.sv
module wsbc_clz #(
  parameter int WIDTH = 32,
  parameter int CNTW  = $clog2(WIDTH) + 1
) (
  input  logic [WIDTH-1:0] src,
  output logic [CNTW-1:0]  count
);
  always_comb begin
    count = CNTW'(WIDTH);
    for (int i = 0; i < WIDTH; i++) begin
      if (src[i]) count = CNTW'(WIDTH - 1 - i);
    end
  end
endmodule

// File: rtl/wsbc_bytecmp.sv
module wsbc_bytecmp #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] mask
);
  localparam int LANES = WIDTH / 8;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign mask[8*g +: 8] = {8{a[8*g +: 8] == b[8*g +: 8]}};
  end
endmodule

// File: rtl/wsbc_unit.sv
module wsbc_unit
  import wsbc_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMMW  = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [OPW-1:0]   in_op,
  input  logic [WIDTH-1:0] in_rs,
  input  logic [WIDTH-1:0] in_rb,
  input  logic [IMMW-1:0]  in_imm,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_result,
  output logic             out_ca,
  output logic             out_ca_we
);
  localparam int AMTW = IMMW + 1;
  localparam int CNTW = IMMW + 1;

  dec_t             dec;
  logic [AMTW-1:0]  amt;
  logic [WIDTH-1:0] sh_res;
  logic             sh_ca;
  logic [CNTW-1:0]  clz_cnt;
  logic [WIDTH-1:0] cmp_mask;
  logic [WIDTH-1:0] ext_res;
  logic [WIDTH-1:0] nxt_result;
  logic             nxt_we;

  assign dec = wsbc_decode(in_op);
  assign amt = dec.use_imm ? {1'b0, in_imm} : in_rb[AMTW-1:0];

  wsbc_shifter #(.WIDTH(WIDTH), .AMTW(AMTW)) u_shift (
    .src(in_rs), .amt(amt), .go_right(dec.go_right), .arith(dec.arith),
    .res(sh_res), .ca(sh_ca)
  );

  wsbc_clz #(.WIDTH(WIDTH), .CNTW(CNTW)) u_clz (
    .src(in_rs), .count(clz_cnt)
  );

  wsbc_bytecmp #(.WIDTH(WIDTH)) u_cmp (
    .a(in_rs), .b(in_rb), .mask(cmp_mask)
  );

  assign ext_res = dec.ext_half ? {{(WIDTH-16){in_rs[15]}}, in_rs[15:0]}
                                : {{(WIDTH-8){in_rs[7]}},  in_rs[7:0]};

  always_comb begin
    nxt_result = '0;
    if (dec.is_shift)     nxt_result = sh_res;
    else if (dec.is_clz)  nxt_result = WIDTH'(clz_cnt);
    else if (dec.is_cmpb) nxt_result = cmp_mask;
    else if (dec.is_ext)  nxt_result = ext_res;
  end

  assign nxt_we = dec.is_shift & dec.arith;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_ca     <= 1'b0;
      out_ca_we  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_ca_we <= in_valid & nxt_we;
      if (in_valid) begin
        out_result <= nxt_result;
        if (nxt_we) out_ca <= sh_ca;
      end
    end
  end
endmodule

// File: rtl/wsbc_unit_chk.sv
module wsbc_unit_chk
  import wsbc_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMMW  = $clog2(WIDTH)
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [OPW-1:0]   in_op,
  input logic [WIDTH-1:0] in_rs,
  input logic [WIDTH-1:0] in_rb,
  input logic             out_valid,
  input logic [WIDTH-1:0] out_result,
  input logic             out_ca,
  input logic             out_ca_we
);
  localparam int BIGB = IMMW;

  logic is_ar;
  assign is_ar = (in_op == OP_SRAW) || (in_op == OP_SRAWI);

  p_issue_lat_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_ca_we && $stable(out_result) && $stable(out_ca)));

  p_slw_sat_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_SLW && in_rb[BIGB]) |=> (out_result == '0));

  p_srw_sat_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_SRW && in_rb[BIGB]) |=> (out_result == '0));

  p_sraw_sat_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_SRAW && in_rb[BIGB]) |=>
      (out_result == {WIDTH{$past(in_rs[WIDTH-1])}} && out_ca == $past(in_rs[WIDTH-1])));

  p_pos_no_ca_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_ar && !in_rs[WIDTH-1]) |=> (out_ca_we && !out_ca));

  p_other_keep_ca_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !is_ar) |=> (!out_ca_we && $stable(out_ca)));

  p_we_with_valid_r8: assert property (@(posedge clk) disable iff (rst)
    out_ca_we |-> out_valid);

  p_clz_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_CLZ && in_rs == '0) |=> (out_result == WIDTH'(WIDTH)));

  p_cmpb_same_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_CMPB && in_rs == in_rb) |=> (out_result == '1));

  p_extb_sign_r11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_EXTB) |=>
      (out_result[WIDTH-1:8] == {(WIDTH-8){$past(in_rs[7])}}));
endmodule

bind wsbc_unit wsbc_unit_chk #(.WIDTH(WIDTH), .IMMW(IMMW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
  .in_rs(in_rs), .in_rb(in_rb), .out_valid(out_valid),
  .out_result(out_result), .out_ca(out_ca), .out_ca_we(out_ca_we)
);

// File: tb/wsbc_unit_tb.sv
module wsbc_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [9:0]  in_op = '0;
  logic [31:0] in_rs = '0;
  logic [31:0] in_rb = '0;
  logic [4:0]  in_imm = '0;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_ca;
  logic        out_ca_we;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic ca_model = 1'b0;

  always #4 clk = ~clk;

  wsbc_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_rs(in_rs), .in_rb(in_rb), .in_imm(in_imm), .out_valid(out_valid),
    .out_result(out_result), .out_ca(out_ca), .out_ca_we(out_ca_we)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Independent model of the requirements.
  task automatic model(input logic [9:0] op, input logic [31:0] rs, input logic [31:0] rb,
                       input logic [4:0] imm, output logic [31:0] res,
                       output logic we, output logic ca);
    int amt;
    bit found;
    int n;
    logic lost;
    res = '0; we = 1'b0; ca = 1'b0;
    amt = (op == 10'd824) ? int'(imm) : int'(rb[5:0]);
    case (op)
      10'd24:  res = (amt >= 32) ? 32'd0 : rs << amt;
      10'd536: res = (amt >= 32) ? 32'd0 : rs >> amt;
      10'd792, 10'd824: begin
        lost = 1'b0;
        for (int i = 0; i < 32; i++) begin
          res[i] = (i + amt < 32) ? rs[i + amt] : rs[31];
          if (i < amt && rs[i]) lost = 1'b1;
        end
        we = 1'b1;
        ca = rs[31] & lost;
      end
      10'd26: begin
        found = 0; n = 0;
        for (int i = 31; i >= 0; i--) begin
          if (!found) begin
            if (rs[i]) found = 1; else n++;
          end
        end
        res = 32'(n);
      end
      10'd508:
        for (int k = 0; k < 4; k++)
          res[8*k +: 8] = (rs[8*k +: 8] == rb[8*k +: 8]) ? 8'hFF : 8'h00;
      10'd954: res = {{24{rs[7]}}, rs[7:0]};
      10'd922: res = {{16{rs[15]}}, rs[15:0]};
      default: res = '0;
    endcase
  endtask

  task automatic run(input logic [9:0] op, input logic [31:0] rs, input logic [31:0] rb,
                     input logic [4:0] imm, input string tag);
    logic [31:0] er;
    logic ew, ec;
    model(op, rs, rb, imm, er, ew, ec);
    if (ew) ca_model = ec;
    in_op = op; in_rs = rs; in_rb = rb; in_imm = imm; in_valid = 1'b1;
    @(negedge clk);
    check({tag, " result"}, out_result, er);
    check({"R2 valid ", tag}, {31'd0, out_valid}, 32'd1);
    check(ew ? "R7 ca_we" : "R8 ca_we", {31'd0, out_ca_we}, {31'd0, ew});
    check(ew ? "R7 ca" : "R8 ca kept", {31'd0, out_ca}, {31'd0, ca_model});
  endtask

  initial begin
    logic [31:0] pats [5];
    logic [31:0] held;
    pats[0] = 32'h8000_0001; pats[1] = 32'hF0F0_1234; pats[2] = 32'h7FFF_FFFF;
    pats[3] = 32'h8000_0000; pats[4] = 32'hFFFF_FFFF;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 valid", {31'd0, out_valid}, 32'd0);
    check("R1 result", out_result, 32'd0);
    check("R1 ca", {31'd0, out_ca}, 32'd0);
    check("R1 ca_we", {31'd0, out_ca_we}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", {29'd0, out_valid, out_ca, out_ca_we}, 32'd0);

    // R3 R4 R5 with junk above bit 5 of the amount word
    for (int p = 0; p < 5; p++) begin
      for (int a = 0; a < 64; a++) begin
        run(10'd24,  pats[p], {26'h2A5_5A3, 6'(a)}, 5'd0, "R3 slw");
        run(10'd536, pats[p], {26'h15A_A5C, 6'(a)}, 5'd0, "R4 srw");
        run(10'd792, pats[p], {26'h3FF_FFF, 6'(a)}, 5'd0, "R5 sraw");
      end
      // R6: immediate amount, rb ignored
      for (int a = 0; a < 32; a++)
        run(10'd824, pats[p], 32'hFFFF_FFE0 ^ 32'(p), 5'(a), "R6 srawi");
    end

    // R7 spot cases
    run(10'd792, 32'h8000_0001, 32'd0, 5'd0, "R7 amt0 neg");
    run(10'd824, 32'h8000_0000, 32'd0, 5'd31, "R7 zeros lost");
    run(10'd792, 32'h8000_0000, 32'd32, 5'd0, "R7 sat neg");

    // R8: carry set, then non-arithmetic opcodes keep it
    run(10'd792, 32'h8000_0001, 32'd1, 5'd0, "R7 set");
    run(10'd24,  32'h1234_5678, 32'd4, 5'd0, "R8 slw");
    run(10'd536, 32'h1234_5678, 32'd4, 5'd0, "R8 srw");
    run(10'd26,  32'h0000_0100, 32'd0, 5'd0, "R8 clz");
    run(10'd508, 32'h1111_2222, 32'h1111_0022, 5'd0, "R8 cmpb");
    run(10'd954, 32'h0000_0080, 32'd0, 5'd0, "R8 extb");
    check("R8 ca still set", {31'd0, out_ca}, 32'd1);

    // R9
    run(10'd26, 32'd0, 32'd0, 5'd0, "R9 clz zero");
    for (int i = 0; i < 32; i++) begin
      run(10'd26, 32'd1 << i, 32'd0, 5'd0, "R9 clz bit");
      run(10'd26, 32'hFFFF_FFFF >> i, 32'd0, 5'd0, "R9 clz ones");
    end

    // R10: every equality mask
    for (int m = 0; m < 16; m++) begin
      logic [31:0] b;
      b = 32'h1122_3344;
      for (int k = 0; k < 4; k++) if (!m[k]) b[8*k +: 8] = b[8*k +: 8] ^ 8'h01;
      run(10'd508, 32'h1122_3344, b, 5'd0, "R10 cmpb");
    end

    // R11
    for (int p = 0; p < 5; p++) begin
      run(10'd954, pats[p] ^ 32'h0000_8080, 32'd0, 5'd0, "R11 extb");
      run(10'd922, pats[p] ^ 32'h0000_8080, 32'd0, 5'd0, "R11 exth");
    end
    run(10'd954, 32'hFFFF_FF7F, 32'd0, 5'd0, "R11 extb pos");
    run(10'd922, 32'hFFFF_7FFF, 32'd0, 5'd0, "R11 exth pos");

    // R12
    run(10'd0,    32'hDEAD_BEEF, 32'd5, 5'd3, "R12 op0");
    run(10'd25,   32'hDEAD_BEEF, 32'd5, 5'd3, "R12 op25");
    run(10'd1023, 32'hDEAD_BEEF, 32'd5, 5'd3, "R12 op1023");

    // R2: idle cycle holds the result
    run(10'd954, 32'h0000_0081, 32'd0, 5'd0, "R11 before idle");
    held = out_result;
    in_valid = 1'b0; in_op = 10'd792; in_rs = 32'hFFFF_FFFF; in_rb = 32'd3;
    @(negedge clk);
    check("R2 idle valid", {31'd0, out_valid}, 32'd0);
    check("R2 idle result", out_result, held);
    check("R2 idle ca_we", {31'd0, out_ca_we}, 32'd0);
    check("R2 idle ca", {31'd0, out_ca}, {31'd0, ca_model});

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule